// File: doc/BRIEF.md
# ECC Fault Injection Controller

This block sits between a memory's storage array and the logic that reads and writes it. It protects each data word with a single-error-correcting, double-error-detecting code of its own. On purpose, it can corrupt the stored word on the write path or the read path, so that software can test how the system reacts to memory errors. A small register file controls it through a simple register port. The controls are a three-bit fault mode, a mask that corrupts check bits, two data-bit pointers, an enable bit, and a fault-reset bit that clears itself. In capture mode the block records the address and the syndrome of the first failing read.

The encoder, the fault mask and the decoder are all combinational. A word presented on `wr_data` leaves on `mem_wr_word` in the same cycle. A word on `mem_rd_word` produces `rd_data`, the error flags and the syndrome in the same cycle. Register writes take effect at the next clock edge.

A capture state machine controls capture and has three states:

- **CAP_IDLE**: capture is not active.
- **CAP_ARMED**: capture is waiting for an erroneous read.
- **CAP_HELD**: the first error has been recorded.

It has five transitions:

- **arm**: from IDLE to ARMED, when enable is set and the mode is capture.
- **hit**: from ARMED to HELD, on a read with `rd_valid` high that the decoder flags as erroneous. The address and syndrome are latched at this point.
- **drop**: from ARMED or HELD back to IDLE, when enable or the capture mode goes away.
- **stay**: remain in the current state in every other case.
- **clear**: a fault reset forces IDLE from any state.

Top module: `ecc_fault_ctl`

## Requirements
- R1: After reset, every register reads 0, and `mem_wr_word` equals the clean code word of `wr_data`.
- R2: With enable at 0, the mode field is ignored. No bit is flipped on either path, and the capture registers do not change.
- R3: Mode 3'b110 with enable flips the stored data bit selected by pointer A on the write path.
- R4: Mode 3'b111 with enable flips the data bits selected by pointer A and pointer B on the write path. When the two pointers are equal, the second bit is pointer A plus 1, modulo the data width.
- R5: Modes 3'b100 and 3'b101 flip the same bits on the read path, before the decoder. One flip raises `rd_single_err` and returns the corrected data. Two flips raise `rd_double_err` only.
- R6: While enable is set and mode bit 2 is 1, each set bit k of the check mask flips code-word bit DW+k on the path that the mode selects. In every other mode the mask has no effect.
- R7: While enable is 1, a write to CTRL updates only the enable bit. The mode and the mask keep their values.
- R8: Writing 1 to CTRL bit 15 clears at the next edge:
  - the mode, the mask, the enable bit and both pointers;
  - the capture registers.

  Bit 15 always reads 0.
- R9: In mode 3'b010 with enable set, the first erroneous read, from one cycle after arming onward, latches `rd_addr` into CAP_ADDR and the syndrome into CAP_SYN. Both are readable in the next cycle. Later errors do not change them.
- R10: The code word has this layout:
  - data at bits [DW-1:0];
  - Hamming check bit j at bit DW+j;
  - overall parity at the top bit.

  Data bits take the Hamming positions 3, 5, 6, 7, 9 and onward. The syndrome is {overall mismatch, Hamming position}.
- R11: The reserved modes 3'b001 and 3'b011 behave like the disabled mode 3'b000.
- R12: Read-path modes leave `mem_wr_word` clean, and write-path modes leave decoding of `mem_rd_word` clean.
- R13: The register map is:
  - CTRL at 0: mode in [2:0], mask in [6:4], enable in bit 8, reset in bit 15;
  - PTR_A at 1;
  - PTR_B at 2;
  - CAP_ADDR at 3, read-only;
  - CAP_SYN at 4, read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on `reg_addr` |
| wr_data | input | DW | Data to be stored |
| mem_wr_word | output | DW+CW | Code word sent to the array, with any write faults applied |
| rd_valid | input | 1 | A read word is present this cycle |
| rd_addr | input | AW | Address of the read |
| mem_rd_word | input | DW+CW | Code word returned by the array |
| rd_data | output | DW | Decoded data, corrected when a single error is found |
| rd_single_err | output | 1 | A correctable error was found |
| rd_double_err | output | 1 | An uncorrectable error was found |
| rd_syndrome | output | CW | Syndrome of the current read |

## Verification
The data paths are combinational. The bench drives `wr_data` or `mem_rd_word` on the falling edge and samples the outputs 1 ns later, inside the same low phase. A register write is presented for one full cycle and takes effect at the rising edge. Every check of its effect on the paths therefore comes at the falling edge after that rising edge. Capture needs two edges after the control write (one to arm, one to latch), so the bench waits one idle cycle before the erroneous read and reads CAP_ADDR and CAP_SYN one cycle after it. Expected code words and syndromes come from the bench's own encoder, built from the layout in R10.

// File: rtl/eccf_pkg.sv
package eccf_pkg;

    typedef enum logic [2:0] {
        FM_OFF     = 3'b000,
        FM_RSV1    = 3'b001,
        FM_CAPTURE = 3'b010,
        FM_RSV3    = 3'b011,
        FM_RD_ONE  = 3'b100,
        FM_RD_TWO  = 3'b101,
        FM_WR_ONE  = 3'b110,
        FM_WR_TWO  = 3'b111
    } fault_mode_e;

    localparam logic [2:0] RA_CTRL     = 3'd0;
    localparam logic [2:0] RA_PTR_A    = 3'd1;
    localparam logic [2:0] RA_PTR_B    = 3'd2;
    localparam logic [2:0] RA_CAP_ADDR = 3'd3;
    localparam logic [2:0] RA_CAP_SYN  = 3'd4;

    localparam int CTRL_MASK_LSB = 4;
    localparam int CTRL_EN_BIT   = 8;
    localparam int CTRL_RST_BIT  = 15;

    // Number of Hamming check bits needed to cover dw data bits.
    function automatic int hamming_p(input int dw);
        int p;
        p = 2;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // Hamming position of data bit i: the (i+1)-th position >= 3 that is not a power of two.
    function automatic int data_pos(input int i);
        int n;
        int r;
        n = 0;
        r = 0;
        for (int q = 3; q < 4096; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == i && r == 0) r = q;
                n++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/eccf_secded.sv
module eccf_secded #(
    parameter int DW = 8,
    localparam int P  = eccf_pkg::hamming_p(DW),
    localparam int CW = P + 1,
    localparam int W  = DW + CW
) (
    input  logic [DW-1:0] enc_data_i,
    output logic [W-1:0]  enc_word_o,
    input  logic [W-1:0]  dec_word_i,
    output logic [DW-1:0] dec_data_o,
    output logic [CW-1:0] dec_syn_o,
    output logic          dec_single_o,
    output logic          dec_double_o
);
    import eccf_pkg::*;

    function automatic logic [P-1:0] check_of(input logic [DW-1:0] d);
        logic [P-1:0] c;
        c = '0;
        for (int j = 0; j < P; j++) begin
            for (int i = 0; i < DW; i++) begin
                if (((data_pos(i) >> j) & 1) != 0) c[j] = c[j] ^ d[i];
            end
        end
        return c;
    endfunction

    logic [P-1:0] enc_chk;
    logic [P-1:0] dec_hsyn;
    logic         dec_ovr;

    always_comb begin
        enc_chk    = check_of(enc_data_i);
        enc_word_o = {^{enc_chk, enc_data_i}, enc_chk, enc_data_i};
    end

    always_comb begin
        dec_hsyn     = dec_word_i[DW +: P] ^ check_of(dec_word_i[DW-1:0]);
        dec_ovr      = ^dec_word_i;
        dec_syn_o    = {dec_ovr, dec_hsyn};
        dec_single_o = dec_ovr;
        dec_double_o = !dec_ovr && (dec_hsyn != '0);
    end

    genvar gi;
    generate
        for (gi = 0; gi < DW; gi++) begin : g_fix
            localparam logic [P-1:0] POS = P'(data_pos(gi));
            assign dec_data_o[gi] = dec_word_i[gi] ^ (dec_ovr && (dec_hsyn == POS));
        end
    endgenerate

endmodule

// File: rtl/eccf_regs.sv
module eccf_regs #(
    parameter int DW  = 8,
    parameter int AW  = 16,
    parameter int CW  = 5,
    parameter int NCF = 3,
    localparam int PW = $clog2(DW)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [2:0]            reg_addr,
    input  logic [15:0]           reg_wdata,
    output logic [15:0]           reg_rdata,
    input  logic [AW-1:0]         cap_addr_i,
    input  logic [CW-1:0]         cap_syn_i,
    output eccf_pkg::fault_mode_e mode_o,
    output logic [NCF-1:0]        cmask_o,
    output logic                  en_o,
    output logic [PW-1:0]         ptr_a_o,
    output logic [PW-1:0]         ptr_b_o,
    output logic                  fault_clr_o
);
    import eccf_pkg::*;

    fault_mode_e    mode_q;
    logic [NCF-1:0] cmask_q;
    logic           en_q;
    logic [PW-1:0]  ptr_a_q;
    logic [PW-1:0]  ptr_b_q;

    assign fault_clr_o = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CTRL_RST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= FM_OFF;
            cmask_q <= '0;
            en_q    <= 1'b0;
            ptr_a_q <= '0;
            ptr_b_q <= '0;
        end else if (fault_clr_o) begin
            mode_q  <= FM_OFF;
            cmask_q <= '0;
            en_q    <= 1'b0;
            ptr_a_q <= '0;
            ptr_b_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    en_q <= reg_wdata[CTRL_EN_BIT];
                    if (!en_q) begin
                        mode_q  <= fault_mode_e'(reg_wdata[2:0]);
                        cmask_q <= reg_wdata[CTRL_MASK_LSB +: NCF];
                    end
                end
                RA_PTR_A: ptr_a_q <= reg_wdata[PW-1:0];
                RA_PTR_B: ptr_b_q <= reg_wdata[PW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[2:0]                    = mode_q;
                reg_rdata[CTRL_MASK_LSB +: NCF]   = cmask_q;
                reg_rdata[CTRL_EN_BIT]            = en_q;
            end
            RA_PTR_A:    reg_rdata[PW-1:0] = ptr_a_q;
            RA_PTR_B:    reg_rdata[PW-1:0] = ptr_b_q;
            RA_CAP_ADDR: reg_rdata[AW-1:0] = cap_addr_i;
            RA_CAP_SYN:  reg_rdata[CW-1:0] = cap_syn_i;
            default: ;
        endcase
    end

    assign mode_o  = mode_q;
    assign cmask_o = cmask_q;
    assign en_o    = en_q;
    assign ptr_a_o = ptr_a_q;
    assign ptr_b_o = ptr_b_q;

    AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CTRL && en_q && !reg_wdata[CTRL_RST_BIT])
        |=> ($stable(mode_q) && $stable(cmask_q))); // R7

    AST_FAULT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr_o |=> (mode_q == FM_OFF && cmask_q == '0 && !en_q
                         && ptr_a_q == '0 && ptr_b_q == '0)); // R8

endmodule

// File: rtl/eccf_flip.sv
module eccf_flip #(
    parameter int DW  = 8,
    parameter int CW  = 5,
    parameter int NCF = 3,
    localparam int PW = $clog2(DW),
    localparam int W  = DW + CW
) (
    input  logic                  en_i,
    input  eccf_pkg::fault_mode_e mode_i,
    input  logic [NCF-1:0]        cmask_i,
    input  logic [PW-1:0]         ptr_a_i,
    input  logic [PW-1:0]         ptr_b_i,
    output logic [W-1:0]          wr_flip_o,
    output logic [W-1:0]          rd_flip_o
);
    logic          inj_any;
    logic          inj_wr;
    logic          inj_two;
    logic [PW-1:0] ptr_b_eff;
    logic [W-1:0]  flip_vec;

    assign inj_any   = en_i && mode_i[2];
    assign inj_wr    = mode_i[1];
    assign inj_two   = mode_i[0];
    assign ptr_b_eff = (ptr_b_i != ptr_a_i) ? ptr_b_i :
                       (ptr_a_i == PW'(DW - 1)) ? '0 : ptr_a_i + 1'b1;

    genvar gb;
    generate
        for (gb = 0; gb < DW; gb++) begin : g_data
            assign flip_vec[gb] = (ptr_a_i == PW'(gb)) || (inj_two && ptr_b_eff == PW'(gb));
        end
        for (gb = 0; gb < CW; gb++) begin : g_chk
            if (gb < NCF) begin : g_masked
                assign flip_vec[DW + gb] = cmask_i[gb];
            end else begin : g_fixed
                assign flip_vec[DW + gb] = 1'b0;
            end
        end
    endgenerate

    assign wr_flip_o = (inj_any && inj_wr)  ? flip_vec : '0;
    assign rd_flip_o = (inj_any && !inj_wr) ? flip_vec : '0;

endmodule

// File: rtl/eccf_capture.sv
module eccf_capture #(
    parameter int AW = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          clr_i,
    input  logic          hit_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] syn_i,
    output logic [AW-1:0] cap_addr_o,
    output logic [CW-1:0] cap_syn_o
);
    typedef enum logic [1:0] {CAP_IDLE, CAP_ARMED, CAP_HELD} cap_state_e;

    cap_state_e    state_q;
    cap_state_e    state_d;
    logic [AW-1:0] cap_addr_q;
    logic [CW-1:0] cap_syn_q;
    logic          load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:  if (active_i) state_d = CAP_ARMED;
            CAP_ARMED: if (!active_i) state_d = CAP_IDLE;
                       else if (hit_i) state_d = CAP_HELD;
            CAP_HELD:  if (!active_i) state_d = CAP_IDLE;
            default:   state_d = CAP_IDLE;
        endcase
        if (clr_i) state_d = CAP_IDLE;
    end

    assign load = (state_q == CAP_ARMED) && active_i && hit_i && !clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr_q <= '0;
            cap_syn_q  <= '0;
        end else if (clr_i) begin
            cap_addr_q <= '0;
            cap_syn_q  <= '0;
        end else if (load) begin
            cap_addr_q <= addr_i;
            cap_syn_q  <= syn_i;
        end
    end

    assign cap_addr_o = cap_addr_q;
    assign cap_syn_o  = cap_syn_q;

    AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_HELD && !clr_i) |=> ($stable(cap_addr_q) && $stable(cap_syn_q))); // R9

    AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !clr_i) |=> ($stable(cap_addr_q) && $stable(cap_syn_q))); // R2

    AST_CAP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cap_addr_q == '0 && cap_syn_q == '0 && state_q == CAP_IDLE)); // R8

endmodule

// File: rtl/ecc_fault_ctl.sv
module ecc_fault_ctl #(
    parameter int DW  = 8,
    parameter int AW  = 16,
    parameter int NCF = 3,
    localparam int CW = eccf_pkg::hamming_p(DW) + 1,
    localparam int W  = DW + CW,
    localparam int PW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic [DW-1:0] wr_data,
    output logic [W-1:0]  mem_wr_word,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    input  logic [W-1:0]  mem_rd_word,
    output logic [DW-1:0] rd_data,
    output logic          rd_single_err,
    output logic          rd_double_err,
    output logic [CW-1:0] rd_syndrome
);
    import eccf_pkg::*;

    fault_mode_e    mode;
    logic [NCF-1:0] cmask;
    logic           en;
    logic [PW-1:0]  ptr_a;
    logic [PW-1:0]  ptr_b;
    logic           fault_clr;
    logic [AW-1:0]  cap_addr;
    logic [CW-1:0]  cap_syn;
    logic [W-1:0]   wr_flip;
    logic [W-1:0]   rd_flip;
    logic [W-1:0]   enc_word;
    logic [W-1:0]   rd_word_f;

    eccf_regs #(.DW(DW), .AW(AW), .CW(CW), .NCF(NCF)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cap_addr_i(cap_addr), .cap_syn_i(cap_syn),
        .mode_o(mode), .cmask_o(cmask), .en_o(en),
        .ptr_a_o(ptr_a), .ptr_b_o(ptr_b), .fault_clr_o(fault_clr)
    );

    eccf_flip #(.DW(DW), .CW(CW), .NCF(NCF)) u_flip (
        .en_i(en), .mode_i(mode), .cmask_i(cmask),
        .ptr_a_i(ptr_a), .ptr_b_i(ptr_b),
        .wr_flip_o(wr_flip), .rd_flip_o(rd_flip)
    );

    assign rd_word_f = mem_rd_word ^ rd_flip;

    eccf_secded #(.DW(DW)) u_code (
        .enc_data_i(wr_data), .enc_word_o(enc_word),
        .dec_word_i(rd_word_f), .dec_data_o(rd_data), .dec_syn_o(rd_syndrome),
        .dec_single_o(rd_single_err), .dec_double_o(rd_double_err)
    );

    assign mem_wr_word = enc_word ^ wr_flip;

    eccf_capture #(.AW(AW), .CW(CW)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .active_i(en && mode == FM_CAPTURE), .clr_i(fault_clr),
        .hit_i(rd_valid && (rd_single_err || rd_double_err)),
        .addr_i(rd_addr), .syn_i(rd_syndrome),
        .cap_addr_o(cap_addr), .cap_syn_o(cap_syn)
    );

    AST_OFF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (mem_wr_word == enc_word && rd_word_f == mem_rd_word)); // R2

    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flip != '0) |-> (rd_word_f == mem_rd_word)); // R12

    AST_TWO_DATA_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == FM_WR_TWO) |-> ($countones(mem_wr_word[DW-1:0] ^ enc_word[DW-1:0]) == 2)); // R4

    AST_ONE_DATA_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == FM_WR_ONE) |-> ($countones(mem_wr_word[DW-1:0] ^ enc_word[DW-1:0]) == 1)); // R3

endmodule

// File: tb/ecc_fault_ctl_test.sv
module ecc_fault_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [7:0]  wr_data = 8'd0;
    logic [12:0] mem_wr_word;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_addr = 16'd0;
    logic [12:0] mem_rd_word = 13'd0;
    logic [7:0]  rd_data;
    logic        rd_single_err;
    logic        rd_double_err;
    logic [4:0]  rd_syndrome;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ecc_fault_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_data(wr_data),
        .mem_wr_word(mem_wr_word), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .mem_rd_word(mem_rd_word), .rd_data(rd_data), .rd_single_err(rd_single_err),
        .rd_double_err(rd_double_err), .rd_syndrome(rd_syndrome)
    );

    always #10 clk = ~clk;

    // Code word per R10: data [7:0] at positions 3,5,6,7,9,10,11,12; check j at bit 8+j; parity at 12.
    function automatic logic [12:0] code_of(input logic [7:0] d);
        int pos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        logic [3:0] c;
        c = 4'd0;
        for (int j = 0; j < 4; j++)
            for (int i = 0; i < 8; i++)
                if (((pos[i] >> j) & 1) != 0) c[j] = c[j] ^ d[i];
        return {^{c, d}, c, d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_mode(input logic [2:0] m, input logic [2:0] mask);
        reg_write(3'd0, 16'h0000);
        reg_write(3'd0, 16'h0100 | {9'd0, mask, 1'b0, m});
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 5; a++) begin
            reg_read(3'(a), v);
            check("R1 reg reset", {16'd0, v}, 32'd0);
        end
        wr_data = 8'hC3; #1;
        check("R1 clean word", {19'd0, mem_wr_word}, {19'd0, code_of(8'hC3)});
    endtask

    task automatic t_disabled;
        reg_write(3'd1, 16'd5);
        reg_write(3'd0, 16'h0006);
        wr_data = 8'h3C; #1;
        check("R2 no flip when disabled", {19'd0, mem_wr_word}, {19'd0, code_of(8'h3C)});
        reg_write(3'd0, 16'h0002);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = 16'h0BAD; mem_rd_word = code_of(8'h11) ^ 13'h0001;
        @(negedge clk);
        rd_valid = 1'b0;
        reg_read(3'd3, reg_wdata);
        check("R2 no capture when disabled", {16'd0, reg_wdata}, 32'd0);
        reg_wdata = 16'd0;
    endtask

    task automatic t_write_single;
        reg_write(3'd1, 16'd5);
        set_mode(3'b110, 3'b000);
        wr_data = 8'h5A; mem_rd_word = code_of(8'h5A); #1;
        check("R3 single write flip", {19'd0, mem_wr_word}, {19'd0, code_of(8'h5A) ^ 13'h0020});
        check("R12 read clean in write mode", {23'd0, rd_single_err, rd_data}, {23'd0, 1'b0, 8'h5A});
    endtask

    task automatic t_write_double;
        reg_write(3'd1, 16'd2);
        reg_write(3'd2, 16'd6);
        set_mode(3'b111, 3'b000);
        wr_data = 8'h0F; #1;
        check("R4 double flip 2,6", {19'd0, mem_wr_word}, {19'd0, code_of(8'h0F) ^ 13'h0044});
        reg_write(3'd2, 16'd2); #1;
        check("R4 equal pointers 2,3", {19'd0, mem_wr_word}, {19'd0, code_of(8'h0F) ^ 13'h000C});
        reg_write(3'd1, 16'd7);
        reg_write(3'd2, 16'd7); #1;
        check("R4 wrap pointers 7,0", {19'd0, mem_wr_word}, {19'd0, code_of(8'h0F) ^ 13'h0081});
    endtask

    task automatic t_read;
        reg_write(3'd1, 16'd4);
        set_mode(3'b100, 3'b000);
        wr_data = 8'hA5; mem_rd_word = code_of(8'hA5); #1;
        check("R5 single read corrected", {23'd0, rd_single_err, rd_data}, {23'd0, 1'b1, 8'hA5});
        check("R10 syndrome data bit 4", {27'd0, rd_syndrome}, 32'h19);
        check("R12 write clean in read mode", {19'd0, mem_wr_word}, {19'd0, code_of(8'hA5)});
        reg_write(3'd1, 16'd1);
        reg_write(3'd2, 16'd3);
        set_mode(3'b101, 3'b000); #1;
        check("R5 double read detected", {30'd0, rd_double_err, rd_single_err}, 32'd2);
    endtask

    task automatic t_mask;
        reg_write(3'd1, 16'd0);
        set_mode(3'b110, 3'b101);
        wr_data = 8'h77; #1;
        check("R6 check-bit mask on write", {19'd0, mem_wr_word}, {19'd0, code_of(8'h77) ^ 13'h0501});
        set_mode(3'b010, 3'b111); #1;
        check("R6 mask ignored in capture mode", {19'd0, mem_wr_word}, {19'd0, code_of(8'h77)});
        reg_write(3'd0, 16'h0000);
        reg_write(3'd1, 16'd6);
        set_mode(3'b100, 3'b010);
        mem_rd_word = code_of(8'h77); #1;
        check("R6 mask on read, double error", {30'd0, rd_double_err, rd_single_err}, 32'd2);
    endtask

    task automatic t_protect;
        logic [15:0] v;
        set_mode(3'b110, 3'b001);
        reg_write(3'd0, 16'h0170);
        reg_read(3'd0, v);
        check("R7 locked while enabled", {16'd0, v}, 32'h0116);
        reg_write(3'd0, 16'h0007);
        reg_read(3'd0, v);
        check("R7 only enable cleared", {16'd0, v}, 32'h0016);
    endtask

    task automatic t_fault_reset;
        logic [15:0] v;
        reg_write(3'd1, 16'd3);
        reg_write(3'd2, 16'd4);
        set_mode(3'b111, 3'b011);
        reg_write(3'd0, 16'h8117);
        reg_read(3'd0, v);
        check("R8 ctrl cleared, bit 15 reads 0", {16'd0, v}, 32'd0);
        reg_read(3'd1, v);
        check("R8 pointer A cleared", {16'd0, v}, 32'd0);
        reg_read(3'd2, v);
        check("R8 pointer B cleared", {16'd0, v}, 32'd0);
    endtask

    task automatic t_capture;
        logic [15:0] v;
        set_mode(3'b010, 3'b000);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = 16'h0111; mem_rd_word = code_of(8'h3C);
        @(negedge clk);
        reg_read(3'd3, v);
        check("R9 clean read not captured", {16'd0, v}, 32'd0);
        rd_addr = 16'h1234; mem_rd_word = code_of(8'h3C) ^ 13'h0008;
        @(negedge clk);
        rd_addr = 16'h5555; mem_rd_word = code_of(8'h3C) ^ 13'h0003;
        reg_read(3'd3, v);
        check("R9 first address captured", {16'd0, v}, 32'h1234);
        reg_read(3'd4, v);
        check("R9 R10 syndrome captured", {16'd0, v}, 32'h17);
        @(negedge clk);
        rd_valid = 1'b0;
        reg_read(3'd3, v);
        check("R9 later error ignored", {16'd0, v}, 32'h1234);
        reg_write(3'd0, 16'h8000);
        reg_read(3'd3, v);
        check("R8 capture address cleared", {16'd0, v}, 32'd0);
        reg_read(3'd4, v);
        check("R8 capture syndrome cleared", {16'd0, v}, 32'd0);
    endtask

    task automatic t_reserved;
        reg_write(3'd1, 16'd2);
        set_mode(3'b001, 3'b111);
        wr_data = 8'h99; mem_rd_word = code_of(8'h99); #1;
        check("R11 mode 001 write clean", {19'd0, mem_wr_word}, {19'd0, code_of(8'h99)});
        set_mode(3'b011, 3'b111); #1;
        check("R11 mode 011 read clean", {22'd0, rd_double_err, rd_single_err, rd_data}, {24'd0, 8'h99});
    endtask

    task automatic t_map;
        logic [15:0] v;
        reg_write(3'd0, 16'h8000);
        reg_write(3'd2, 16'd5);
        reg_read(3'd2, v);
        check("R13 pointer B readback", {16'd0, v}, 32'd5);
        reg_write(3'd3, 16'hFFFF);
        reg_read(3'd3, v);
        check("R13 capture address read-only", {16'd0, v}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_disabled;
        t_write_single;
        t_write_double;
        t_read;
        t_mask;
        t_protect;
        t_fault_reset;
        t_capture;
        t_reserved;
        t_map;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule